// File: doc/BRIEF.md
# Table-Driven AES Round Unit

This block computes one forward AES round on a 128-bit state, on request. A caller presents the current state, the 128-bit round key and a flag marking the last round, then pulses a start input. The unit captures all three and spends four cycles building the output one 32-bit column at a time. In each of those cycles it makes four reads of a single combined substitution-and-mix table. A fifth cycle moves the finished state to the output and raises a one-cycle done pulse.

Only one table is held. Its four views are made by rotating each table word by whole bytes, according to the state row the looked-up byte came from. The byte feeding each read follows the ShiftRows pattern. For the last round the mixing part is dropped and only the substituted byte goes into the key XOR. The table word is computed from a combinational S-box and doubling function, so no stored contents are needed.

Top module: `aes_round_unit`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0 and `result_o` is all zeros.
- R2: A start is accepted on a rising edge where `start_i` is 1 and `busy_o` is 0. `busy_o` is 1 from that edge until the fifth edge after it, and `done_o` is 1 in the cycle after the fifth edge.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: A start given while `busy_o` is 1 is ignored. It changes neither the result of the round in progress nor its timing, and it produces no extra done pulse.
- R5: The 128-bit packing is fixed. The byte at state row r and column c is `x[127-8*(4c+r) -: 8]`. With the last flag clear, the result equals MixColumns(ShiftRows(SubBytes(state))) XOR key. In this packing, output row r of column j takes input byte (row r, column (j+r) mod 4).
- R6: With the last flag set, the result equals ShiftRows(SubBytes(state)) XOR key, with no column mixing.
- R7: State, key and last flag are sampled only on the accepting edge. Changes to them during the round do not affect the result.
- R8: `result_o` keeps its value from one done pulse until the next.
- R9: A start given in the same cycle that `done_o` is high is accepted, so rounds can run back to back every five cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a round; taken only when idle |
| last_i | input | 1 | Last-round flag: skip column mixing |
| state_i | input | 128 | Round input state |
| rkey_i | input | 128 | Round key |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 128 | Round output state |

## Verification
The hardest case to reach from the ports is a start raised while a round is running, carrying a different state, key and flag. To make a wrong capture visible, the request must be dropped before the done cycle, because a start in the done cycle is legitimately accepted. The stimulus holds start high with unrelated inputs for three busy cycles after an accepted round and releases it two edges before done. It then checks the completion edge, the result of the original inputs, and that no second pulse follows. The row-rotation paths are only told apart by states whose rows differ, so vectors with distinct bytes in every row and column are used alongside the all-zero cases.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_ROW  = 4;
  localparam int unsigned NUM_COL  = 4;
  localparam int unsigned WORD_W   = BYTE_W * NUM_ROW;
  localparam int unsigned BLOCK_W  = WORD_W * NUM_COL;
  localparam int unsigned COL_IW   = $clog2(NUM_COL);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_LATCH = 2'd2
  } phase_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // a^254 by square-and-multiply; zero maps to zero
  function automatic logic [7:0] gf_recip(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    gf_recip = acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int unsigned n);
    logic [15:0] d;
    d = {v, v} << n;
    rotl8 = d[15:8];
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] q;
    q = gf_recip(a);
    sub_byte = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction

  // base view of the combined table, row 0 in the top byte
  function automatic logic [WORD_W-1:0] table_word(input logic [7:0] a, input logic last);
    logic [7:0] s;
    s = sub_byte(a);
    if (last) table_word = {s, 24'h000000};
    else      table_word = {gf_dbl(s), s, s, gf_dbl(s) ^ s};
  endfunction

endpackage

// File: rtl/aes_tbl_port.sv
module aes_tbl_port
  import aes_rnd_pkg::*;
#(
  parameter int unsigned ROW = 0
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned SHIFT = BYTE_W * ROW;

  logic [WORD_W-1:0] base_word;

  always_comb base_word = table_word(byte_i, last_i);

  generate
    if (SHIFT == 0) begin : g_plain
      always_comb word_o = base_word;
    end else begin : g_rot
      always_comb word_o = {base_word[SHIFT-1:0], base_word[WORD_W-1:SHIFT]};
    end
  endgenerate

endmodule

// File: rtl/aes_col_engine.sv
module aes_col_engine
  import aes_rnd_pkg::*;
(
  input  logic [BLOCK_W-1:0] state_i,
  input  logic [COL_IW-1:0]  col_i,
  input  logic [WORD_W-1:0]  key_word_i,
  input  logic               last_i,
  output logic [WORD_W-1:0]  col_o
);

  logic [WORD_W-1:0] lane_word [NUM_ROW];

  generate
    for (genvar r = 0; r < NUM_ROW; r++) begin : g_lane
      localparam logic [WORD_W-1:0] KEEP = {BYTE_W{1'b1}} << (WORD_W - BYTE_W * (r + 1));
      logic [COL_IW-1:0] src_col;
      logic [BYTE_W-1:0] pick;
      logic [WORD_W-1:0] word;

      always_comb begin
        src_col = col_i + COL_IW'(r);
        pick    = state_i[BLOCK_W - 1 - BYTE_W * (NUM_ROW * int'(src_col) + r) -: BYTE_W];
      end

      aes_tbl_port #(.ROW(r)) u_port (
        .byte_i (pick),
        .last_i (last_i),
        .word_o (word)
      );

      always_comb lane_word[r] = word;

      // last-round lookups may only touch their own row byte
      always_comb begin
        if (last_i === 1'b1) begin
          assert_last_lane_R6: assert ((word & ~KEEP) == '0)
            else $error("last-round lane %0d leaks into other rows", r);
        end
      end
    end
  endgenerate

  always_comb begin
    col_o = key_word_i;
    for (int r = 0; r < NUM_ROW; r++) col_o = col_o ^ lane_word[r];
  end

endmodule

// File: rtl/aes_rnd_seq.sv
module aes_rnd_seq
  import aes_rnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              step_o,
  output logic              latch_o,
  output logic [COL_IW-1:0] col_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [COL_IW-1:0] LAST_COL = COL_IW'(NUM_COL - 1);

  phase_t            phase_q;
  logic [COL_IW-1:0] col_q;
  logic              done_q;

  always_comb begin
    accept_o = (phase_q == PH_IDLE) && start_i;
    step_o   = (phase_q == PH_RUN);
    latch_o  = (phase_q == PH_LATCH);
    busy_o   = (phase_q != PH_IDLE);
    col_o    = col_q;
    done_o   = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= latch_o;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_RUN;
            col_q   <= '0;
          end
        end
        PH_RUN: begin
          if (col_q == LAST_COL) phase_q <= PH_LATCH;
          col_q <= col_q + 1'b1;
        end
        PH_LATCH: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_col_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && col_q != LAST_COL) |=> (step_o && col_q == COL_IW'($past(col_q) + 1'b1)))
    else $error("column walk broken");

  assert_run_to_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && col_q == LAST_COL) |=> latch_o)
    else $error("last column not followed by latch");

  assert_accept_first_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (step_o && col_q == '0))
    else $error("accepted start did not begin at column 0");

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  assert_done_after_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(latch_o))
    else $error("done without latch phase");

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_rnd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         last_i,
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [127:0] result_o
);

  logic               accept_fire;
  logic               step_fire;
  logic               latch_fire;
  logic [COL_IW-1:0]  cur_col;
  logic [BLOCK_W-1:0] st_q;
  logic [BLOCK_W-1:0] key_q;
  logic               last_q;
  logic [BLOCK_W-1:0] acc_q;
  logic [BLOCK_W-1:0] result_q;
  logic [WORD_W-1:0]  key_word;
  logic [WORD_W-1:0]  col_word;

  aes_rnd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept_fire),
    .step_o   (step_fire),
    .latch_o  (latch_fire),
    .col_o    (cur_col),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_comb key_word = key_q[BLOCK_W - 1 - WORD_W * int'(cur_col) -: WORD_W];

  aes_col_engine u_col (
    .state_i    (st_q),
    .col_i      (cur_col),
    .key_word_i (key_word),
    .last_i     (last_q),
    .col_o      (col_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      key_q    <= '0;
      last_q   <= 1'b0;
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      if (accept_fire) begin
        st_q   <= state_i;
        key_q  <= rkey_i;
        last_q <= last_i;
      end
      if (step_fire) acc_q[BLOCK_W - 1 - WORD_W * int'(cur_col) -: WORD_W] <= col_word;
      if (latch_fire) result_q <= acc_q;
    end
  end

  always_comb result_o = result_q;

  assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(st_q) && $stable(key_q) && $stable(last_q)))
    else $error("start taken while busy");

  assert_inputs_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_fire |=> ($stable(st_q) && $stable(key_q)))
    else $error("operands changed without accept");

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> $stable(result_o))
    else $error("result changed outside latch");

  assert_done_marks_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> done_o)
    else $error("result latched without done");

endmodule

// File: tb/test_aes_round_unit.sv
`timescale 1ns/1ps
module test_aes_round_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         last_i = 1'b0;
  logic [127:0] state_i = '0;
  logic [127:0] rkey_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] sb [256];

  always #4 clk = ~clk;

  aes_round_unit i_aes_round_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .last_i   (last_i),
    .state_i  (state_i),
    .rkey_i   (rkey_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // S-box built by walking the multiplicative group with generator 3
  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [7:0] m2(input logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] x, input int c, input int r);
    return x[127 - 8*(4*c + r) -: 8];
  endfunction

  function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k, input bit fin);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] e [4];
    for (int c = 0; c < 4; c++) begin
      a0 = sb[gb(s, c, 0)];
      a1 = sb[gb(s, (c + 1) % 4, 1)];
      a2 = sb[gb(s, (c + 2) % 4, 2)];
      a3 = sb[gb(s, (c + 3) % 4, 3)];
      if (fin) begin
        e[0] = a0; e[1] = a1; e[2] = a2; e[3] = a3;
      end else begin
        e[0] = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
        e[1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
        e[2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
        e[3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
      end
      for (int r = 0; r < 4; r++) o[127 - 8*(4*c + r) -: 8] = e[r] ^ gb(k, c, r);
    end
    return o;
  endfunction

  // drive at a falling edge; returns at the falling edge after the accept edge
  task automatic launch(input logic [127:0] s, input logic [127:0] k, input bit fin);
    state_i = s; rkey_i = k; last_i = fin; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after accept", {127'd0, busy_o}, 128'd1);
  endtask

  task automatic await_done(output int lat);
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o) break;
      chk(busy_o == 1'b1, "R2", "busy while running", {127'd0, busy_o}, 128'd1);
    end
  endtask

  task automatic run_and_check(input logic [127:0] s, input logic [127:0] k, input bit fin, input string req);
    int lat;
    launch(s, k, fin);
    await_done(lat);
    chk(lat == 5, "R2", "latency", 128'(lat), 128'd5);
    chk(result_o == ref_round(s, k, fin), req, "round value", result_o, ref_round(s, k, fin));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R1", "done in reset", {127'd0, done_o}, 128'd0);
    chk(busy_o == 1'b0, "R1", "busy in reset", {127'd0, busy_o}, 128'd0);
    chk(result_o == '0, "R1", "result in reset", result_o, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after release", {126'd0, busy_o, done_o}, 128'd0);
  endtask

  task automatic t_zero_known();
    run_and_check('0, '0, 1'b1, "R6");
    chk(result_o == {16{8'h63}}, "R6", "zero state last round", result_o, {16{8'h63}});
    run_and_check('0, '0, 1'b0, "R5");
    chk(result_o == {16{8'h63}}, "R5", "zero state full round", result_o, {16{8'h63}});
  endtask

  task automatic t_patterns();
    run_and_check(128'h00112233_44556677_8899AABB_CCDDEEFF, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 1'b0, "R5");
    run_and_check(128'h00102030_01112131_02122232_03132333, '0, 1'b0, "R5");
    run_and_check(128'h00102030_01112131_02122232_03132333, '0, 1'b1, "R6");
    for (int i = 0; i < 6; i++) begin
      logic [127:0] s, k;
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      run_and_check(s, k, i[0], i[0] ? "R6" : "R5");
    end
  endtask

  task automatic t_ignore_start();
    logic [127:0] sa, ka, exp;
    int lat;
    sa = 128'hDEADBEEF_01234567_89ABCDEF_F0E1D2C3;
    ka = 128'h11111111_22222222_33333333_44444444;
    exp = ref_round(sa, ka, 1'b0);
    launch(sa, ka, 1'b0);
    state_i = ~sa; rkey_i = ~ka; last_i = 1'b1; start_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
    await_done(lat);
    chk(lat == 2, "R4", "done edge with start held while busy", 128'(lat + 3), 128'd5);
    chk(result_o == exp, "R4", "result ignores busy start", result_o, exp);
    @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R3", "single done pulse", {127'd0, done_o}, 128'd0);
    chk(busy_o == 1'b0, "R4", "no stray round started", {127'd0, busy_o}, 128'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result_o == exp, "R8", "result held while idle", result_o, exp);
  endtask

  task automatic t_input_hold();
    logic [127:0] sa, ka, exp;
    int lat;
    sa = 128'h3243F6A8_885A308D_313198A2_E0370734;
    ka = 128'hA0FAFE17_88542CB1_23A33939_2A6C7605;
    exp = ref_round(sa, ka, 1'b1);
    launch(sa, ka, 1'b1);
    state_i = 128'h5A5A5A5A_A5A5A5A5_0F0F0F0F_F0F0F0F0; rkey_i = '1; last_i = 1'b0;
    await_done(lat);
    chk(result_o == exp, "R7", "operands sampled at accept", result_o, exp);
  endtask

  task automatic t_back_to_back();
    logic [127:0] s1, s2, k1, k2, e1;
    int lat;
    s1 = 128'h01020304_05060708_090A0B0C_0D0E0F10; k1 = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
    s2 = 128'hF0F1F2F3_F4F5F6F7_F8F9FAFB_FCFDFEFF; k2 = 128'h0;
    e1 = ref_round(s1, k1, 1'b0);
    launch(s1, k1, 1'b0);
    await_done(lat);
    chk(result_o == e1, "R9", "first of pair", result_o, e1);
    launch(s2, k2, 1'b0);
    chk(result_o == e1, "R8", "result held during next round", result_o, e1);
    await_done(lat);
    chk(lat == 5, "R9", "second of pair latency", 128'(lat), 128'd5);
    chk(result_o == ref_round(s2, k2, 1'b0), "R9", "second of pair", result_o, ref_round(s2, k2, 1'b0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_sbox();
    t_reset();
    t_zero_known();
    t_patterns();
    t_ignore_start();
    t_input_hold();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule